// File: doc/BRIEF.md
# Three-Digit Multiplexed Scan and Dimmer

This block is the time base for a display driven at one-third duty. A slot counter advances on an oscillator-clock enable and visits three digits in fixed order. Each digit keeps the whole slot. While a digit's slot runs, the segment outputs carry that digit's row of pattern bits. The digit-enable output is on only for a window inside the slot. The width of that window comes from a dimmer code, so lowering the code dims the display without touching the pattern.

Every slot has the same layout. It opens with a fixed two-clock dark gap. The on-window follows, lasting two clocks per dimmer step. The rest of the slot is dark until the slot ends. A new dimmer code takes effect only when a frame rolls over, so no slot is cut short by a change. A display-enable input pulls every output low while the scan and the dimmer capture keep running. Reset does the same and parks the scan at the first digit, position zero, with a dimmer value of zero.

Top module: `mux_scan_dimmer`

## Requirements
- R1: While reset is high, and in the clock after it, digit_o and seg_o are all zero. Reset restarts the scan at digit 0, position 0. The stored dimmer value is zero until the first frame boundary, so no digit lights in the first frame after reset.
- R2: A slot lasts 2^(DIM_W+1) enabled clocks. Slots visit digits 0, 1, 2 and then repeat, so a frame is three slots. digit_o bit d belongs to digit d, and at most one bit is ever set.
- R3: With show_en high and stored dimmer value m, the digit's bit is set at slot positions 2 through 2+2m-1 and clear everywhere else. Positions 0 and 1 are always dark. Each output reflects the scan position one clock earlier.
- R4: A dimmer code of all ones is stored as all ones minus one, which leaves exactly two dark clocks at the end of the slot.
- R5: A dimmer code of zero keeps every digit bit clear for the whole frame, while the segments still show the data.
- R6: During digit d's slot, seg_o[n] equals seg_data[d*SEGS+n]. The row is captured as the slot starts and holds for the whole slot. The first slot after reset shows zeros.
- R7: With show_en low, digit_o and seg_o are zero one clock later. Scanning and dimmer capture go on regardless.
- R8: dim_code is sampled only at the enabled clock that ends digit 2's slot. A change in the middle of a frame has no effect on the rest of that frame.
- R9: While osc_en is low, the scan position and the outputs hold. Progress resumes exactly where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | Oscillator-clock enable; the scan advances once per high cycle |
| show_en | input | 1 | Display enable; low blanks all outputs |
| dim_code | input | DIM_W | Dimmer code, on-time in units of two clocks |
| seg_data | input | DIGITS*SEGS | Pattern bits, row d at bits d*SEGS upward |
| digit_o | output | DIGITS | Registered one-hot digit enables |
| seg_o | output | SEGS | Registered segment outputs |

## Verification
The bench builds the block with DIM_W=4 and SEGS=8, which gives a 32-clock slot and a 96-clock frame. With these values the all-ones code, the zero code and a mid-frame code change each fit into a handful of frames, and every sample can be compared with a reference computed in the bench. The three-digit order and the two-clock gap and tail keep their full-size shape, because those depend on the dimmer step and not on the code width. Stalled and alternating clock enables are exercised at this size too.

// File: rtl/mux_scan_pkg.sv
package mux_scan_pkg;

    // Dark clocks at the head of every slot, independent of the dimmer.
    localparam int GAP_CLKS = 2;

    // Where inside a slot the scan currently sits.
    typedef enum logic [1:0] {
        PH_GAP  = 2'd0,
        PH_ON   = 2'd1,
        PH_TAIL = 2'd2
    } slot_phase_e;

    // Slot length for a dimmer code of the given width: two clocks per step.
    function automatic int slot_clks(input int dim_w);
        return 2 << dim_w;
    endfunction

endpackage

// File: rtl/mux_scan_timer.sv
module mux_scan_timer #(
    parameter int DIGITS = 3,
    parameter int SLOT_W = 11,
    localparam int DIG_W = $clog2(DIGITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    output logic [SLOT_W-1:0] pos_o,
    output logic [DIG_W-1:0]  dig_o,
    output logic [DIG_W-1:0]  next_dig_o,
    output logic              slot_end_o,
    output logic              frame_end_o
);
    localparam logic [SLOT_W-1:0] POS_LAST = '1;
    localparam logic [DIG_W-1:0]  DIG_LAST = DIG_W'(DIGITS - 1);

    logic [SLOT_W-1:0] pos_q;
    logic [DIG_W-1:0]  dig_q;
    logic              at_end;

    assign at_end      = (pos_q == POS_LAST);
    assign slot_end_o  = tick_en && at_end;
    assign frame_end_o = slot_end_o && (dig_q == DIG_LAST);
    assign next_dig_o  = (dig_q == DIG_LAST) ? '0 : dig_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
            dig_q <= '0;
        end else if (tick_en) begin
            pos_q <= pos_q + 1'b1;
            if (at_end) begin
                dig_q <= next_dig_o;
            end
        end
    end

    assign pos_o = pos_q;
    assign dig_o = dig_q;
endmodule

// File: rtl/mux_scan_dim_gate.sv
module mux_scan_dim_gate
    import mux_scan_pkg::*;
#(
    parameter int DIM_W = 10,
    localparam int SLOT_W = DIM_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_end,
    input  logic [DIM_W-1:0]  dim_code,
    input  logic [SLOT_W-1:0] pos,
    output logic [DIM_W-1:0]  dm_o,
    output slot_phase_e       phase_o
);
    localparam logic [DIM_W-1:0]  CODE_TOP = {{(DIM_W-1){1'b1}}, 1'b0};
    localparam logic [SLOT_W:0]   GAP_W    = (SLOT_W+1)'(GAP_CLKS);

    logic [DIM_W-1:0] dm_q;
    logic [DIM_W-1:0] code_clamped;
    logic [SLOT_W:0]  on_limit;
    logic [SLOT_W:0]  pos_x;

    // The all-ones code is reserved; fold it onto the largest legal step.
    assign code_clamped = (dim_code == '1) ? CODE_TOP : dim_code;

    always_ff @(posedge clk) begin
        if (rst) begin
            dm_q <= '0;
        end else if (frame_end) begin
            dm_q <= code_clamped;
        end
    end

    // Window end = gap + two clocks per step.
    assign on_limit = GAP_W + {1'b0, dm_q, 1'b0};
    assign pos_x    = {1'b0, pos};

    always_comb begin
        if (pos_x < GAP_W) begin
            phase_o = PH_GAP;
        end else if (pos_x < on_limit) begin
            phase_o = PH_ON;
        end else begin
            phase_o = PH_TAIL;
        end
    end

    assign dm_o = dm_q;
endmodule

// File: rtl/mux_scan_row_pick.sv
module mux_scan_row_pick #(
    parameter int SEGS   = 24,
    parameter int DIGITS = 3,
    localparam int DIG_W = $clog2(DIGITS),
    localparam int ROWS  = 1 << DIG_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   slot_end,
    input  logic [DIG_W-1:0]       next_dig,
    input  logic [DIGITS*SEGS-1:0] seg_data,
    output logic [SEGS-1:0]        row_o
);
    logic [SEGS-1:0] rows [ROWS];
    logic [SEGS-1:0] row_q;

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        if (g < DIGITS) begin : g_live
            assign rows[g] = seg_data[g*SEGS +: SEGS];
        end else begin : g_pad
            assign rows[g] = '0;
        end
    end

    // Capture the coming digit's row on the edge that opens its slot.
    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
        end else if (slot_end) begin
            row_q <= rows[next_dig];
        end
    end

    assign row_o = row_q;
endmodule

// File: rtl/mux_scan_dimmer.sv
module mux_scan_dimmer
    import mux_scan_pkg::*;
#(
    parameter int SEGS   = 24,
    parameter int DIGITS = 3,
    parameter int DIM_W  = 10
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   osc_en,
    input  logic                   show_en,
    input  logic [DIM_W-1:0]       dim_code,
    input  logic [DIGITS*SEGS-1:0] seg_data,
    output logic [DIGITS-1:0]      digit_o,
    output logic [SEGS-1:0]        seg_o
);
    localparam int SLOT_W = DIM_W + 1;
    localparam int DIG_W  = $clog2(DIGITS);

    logic [SLOT_W-1:0] pos_q;
    logic [DIG_W-1:0]  dig_q;
    logic [DIG_W-1:0]  next_dig;
    logic              slot_end;
    logic              frame_end;
    logic [DIM_W-1:0]  dm_q;
    slot_phase_e       phase;
    logic [SEGS-1:0]   row_q;
    logic [DIGITS-1:0] dig_hot;

    mux_scan_timer #(
        .DIGITS (DIGITS),
        .SLOT_W (SLOT_W)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .tick_en     (osc_en),
        .pos_o       (pos_q),
        .dig_o       (dig_q),
        .next_dig_o  (next_dig),
        .slot_end_o  (slot_end),
        .frame_end_o (frame_end)
    );

    mux_scan_dim_gate #(
        .DIM_W (DIM_W)
    ) u_dim (
        .clk       (clk),
        .rst       (rst),
        .frame_end (frame_end),
        .dim_code  (dim_code),
        .pos       (pos_q),
        .dm_o      (dm_q),
        .phase_o   (phase)
    );

    mux_scan_row_pick #(
        .SEGS   (SEGS),
        .DIGITS (DIGITS)
    ) u_rows (
        .clk      (clk),
        .rst      (rst),
        .slot_end (slot_end),
        .next_dig (next_dig),
        .seg_data (seg_data),
        .row_o    (row_q)
    );

    assign dig_hot = DIGITS'(1) << dig_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            digit_o <= '0;
            seg_o   <= '0;
        end else begin
            digit_o <= (show_en && phase == PH_ON) ? dig_hot : '0;
            seg_o   <= show_en ? row_q : '0;
        end
    end
endmodule

// File: rtl/mux_scan_dimmer_chk.sv
module mux_scan_dimmer_chk #(
    parameter int SEGS   = 24,
    parameter int DIGITS = 3,
    parameter int DIM_W  = 10,
    localparam int SLOT_W = DIM_W + 1,
    localparam int DIG_W  = $clog2(DIGITS)
) (
    input logic              clk,
    input logic              rst,
    input logic              osc_en,
    input logic              show_en,
    input logic [DIGITS-1:0] digit_o,
    input logic [SEGS-1:0]   seg_o,
    input logic [SLOT_W-1:0] pos_q,
    input logic [DIG_W-1:0]  dig_q,
    input logic [DIM_W-1:0]  dm_q,
    input logic              frame_end
);
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (digit_o == '0 && seg_o == '0 && pos_q == '0 && dig_q == '0));

    p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(digit_o));

    p_advance_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(dig_q) |-> $past(pos_q == '1 && osc_en));

    p_gap_r3: assert property (@(posedge clk) disable iff (rst)
        (pos_q < SLOT_W'(2)) |=> (digit_o == '0));

    p_clamp_r4: assert property (@(posedge clk) disable iff (rst)
        dm_q != '1);

    p_blank_r7: assert property (@(posedge clk) disable iff (rst)
        !show_en |=> (digit_o == '0 && seg_o == '0));

    p_frame_load_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(dm_q) |-> $past(frame_end));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !osc_en |=> ($stable(pos_q) && $stable(dig_q)));
endmodule

bind mux_scan_dimmer mux_scan_dimmer_chk #(
    .SEGS   (SEGS),
    .DIGITS (DIGITS),
    .DIM_W  (DIM_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .osc_en    (osc_en),
    .show_en   (show_en),
    .digit_o   (digit_o),
    .seg_o     (seg_o),
    .pos_q     (pos_q),
    .dig_q     (dig_q),
    .dm_q      (dm_q),
    .frame_end (frame_end)
);

// File: tb/test_mux_scan_dimmer.sv
module test_mux_scan_dimmer;
    localparam int SEGS   = 8;
    localparam int DIGITS = 3;
    localparam int DIM_W  = 4;
    localparam int SLOT   = 32;
    localparam int FRAME  = 96;

    // {toggle_en, show, dim code, row2 row1 row0}
    localparam logic [29:0] VEC [0:6] = '{
        {1'b0, 1'b1, 4'd1,  24'h0F3CA5},
        {1'b0, 1'b1, 4'd14, 24'hFF0081},
        {1'b0, 1'b1, 4'd15, 24'h5A5AC3},
        {1'b0, 1'b1, 4'd0,  24'h123456},
        {1'b0, 1'b0, 4'd7,  24'hFFFFFF},
        {1'b1, 1'b1, 4'd5,  24'h81C3E7},
        {1'b0, 1'b1, 4'd3,  24'hAA55F0}
    };

    logic clk = 1'b0;
    logic rst;
    logic osc_en;
    logic show_en;
    logic [DIM_W-1:0] dim_code;
    logic [DIGITS*SEGS-1:0] seg_data;
    logic [DIGITS-1:0] digit_o;
    logic [SEGS-1:0] seg_o;

    int checks = 0;
    int failures = 0;
    int idx = -1;
    int en_cnt = 0;
    bit toggle_en = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mux_scan_dimmer #(
        .SEGS   (SEGS),
        .DIGITS (DIGITS),
        .DIM_W  (DIM_W)
    ) i_mux_scan_dimmer (
        .clk      (clk),
        .rst      (rst),
        .osc_en   (osc_en),
        .show_en  (show_en),
        .dim_code (dim_code),
        .seg_data (seg_data),
        .digit_o  (digit_o),
        .seg_o    (seg_o)
    );

    // idx = enabled edges seen before the latest edge = scan position the outputs show
    task automatic tick();
        logic en_at;
        @(posedge clk);
        en_at = osc_en;
        @(negedge clk);
        if (!rst) begin
            idx = en_cnt;
            if (en_at) en_cnt++;
        end
        if (toggle_en) osc_en = ~osc_en;
    endtask

    task automatic check_out(input int dm, input logic [23:0] rows, input logic sh,
                             input bit dig_only, input string dtag, input string stag);
        int pos;
        int d;
        int dme;
        logic [DIGITS-1:0] ed;
        logic [SEGS-1:0] es;
        pos = idx % SLOT;
        d = (idx / SLOT) % DIGITS;
        dme = (dm == 15) ? 14 : dm;
        ed = (sh && pos >= 2 && pos < 2 + 2 * dme) ? DIGITS'(1 << d) : '0;
        es = sh ? rows[d*SEGS +: SEGS] : '0;
        checks++;
        if (digit_o !== ed) begin
            failures++;
            $display("FAIL %s digit_o=%b expected=%b at idx %0d", dtag, digit_o, ed, idx);
        end
        if (!dig_only) begin
            checks++;
            if (seg_o !== es) begin
                failures++;
                $display("FAIL %s seg_o=%h expected=%h at idx %0d", stag, seg_o, es, idx);
            end
        end
    endtask

    task automatic check_zero(input string tag);
        checks++;
        if (digit_o !== '0 || seg_o !== '0) begin
            failures++;
            $display("FAIL %s digit_o=%b seg_o=%h expected=0", tag, digit_o, seg_o);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int cur_dm;
        logic [23:0] cur_rows;
        logic cur_show;
        int tf;
        rst = 1'b1;
        osc_en = 1'b1;
        show_en = 1'b1;
        dim_code = 4'd14;
        seg_data = 24'hC3A5F0;
        repeat (4) tick();
        check_zero("R1 during reset");

        @(negedge clk);
        rst = 1'b0;
        en_cnt = 0;
        // R1: first frame after reset keeps digits dark
        tick();
        while (idx < FRAME) begin
            check_out(0, 24'h0, 1'b1, 1'b1, "R1", "R1");
            tick();
        end
        cur_dm = 14;
        cur_rows = 24'hC3A5F0;
        cur_show = 1'b1;

        foreach (VEC[v]) begin
            while ((idx % FRAME) < FRAME / 2) tick();
            tf = idx / FRAME + 1;
            toggle_en = VEC[v][29];
            show_en = VEC[v][28];
            dim_code = VEC[v][27:24];
            seg_data = VEC[v][23:0];
            tick();
            // R8: rest of this frame still uses the old stored dimmer value
            while (idx / FRAME < tf) begin
                check_out(cur_dm, cur_rows, show_en, 1'b1, "R8", "R8");
                tick();
            end
            cur_dm = int'(VEC[v][27:24]);
            cur_rows = VEC[v][23:0];
            cur_show = VEC[v][28];
            while (idx / FRAME == tf) begin
                if (!cur_show)
                    check_out(cur_dm, cur_rows, cur_show, 1'b0, "R7", "R7");
                else if (cur_dm == 15)
                    check_out(cur_dm, cur_rows, cur_show, 1'b0, "R4", "R6");
                else if (cur_dm == 0)
                    check_out(cur_dm, cur_rows, cur_show, 1'b0, "R5", "R6");
                else if (VEC[v][29])
                    check_out(cur_dm, cur_rows, cur_show, 1'b0, "R9", "R6");
                else
                    check_out(cur_dm, cur_rows, cur_show, 1'b0, "R2 R3", "R6");
                tick();
            end
            toggle_en = 1'b0;
            osc_en = 1'b1;
        end

        // R9: stall while a digit is lit, then resume
        while ((idx % FRAME) != SLOT + 4) tick();
        osc_en = 1'b0;
        repeat (20) begin
            tick();
            check_out(cur_dm, cur_rows, cur_show, 1'b0, "R9", "R9");
        end
        osc_en = 1'b1;
        tf = idx / FRAME;
        tick();
        while (idx / FRAME == tf) begin
            check_out(cur_dm, cur_rows, cur_show, 1'b0, "R9", "R6");
            tick();
        end

        // R1: reset in mid-run clears outputs on the next edge
        while ((idx % SLOT) != 5) tick();
        rst = 1'b1;
        tick();
        check_zero("R1 mid-run reset");
        tick();
        check_zero("R1 held reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule